// File: doc/BRIEF.md
# Lockable Software-Loaded Translation Buffer

This block is a fully associative address translation buffer whose contents are written only by a host. The host uses a small register port to stage two words. The tag word holds the virtual tag, the page size and two flags. The data word holds the physical base and the page attributes. A write to the load register then copies both words into the entry chosen by a victim pointer. The low part of the entry array can be locked: the victim pointer never goes below a programmable base, and after each load it steps forward and wraps back to that base.

Four page sizes share the array: 4 KB, 64 KB, 1 MB and 16 MB. The page size stored in each entry sets how many virtual address bits take part in the tag compare. The untranslated low address bits pass straight through into the physical address. An entry can be marked preserved, which protects it from a whole-buffer flush. A single-entry flush, driven by a staged tag and size, removes the matching entry whether or not it is preserved. A lookup port takes a 32-bit virtual address and gives hit, physical address and attributes one cycle later.

Top module: `lockableTlb`

## Requirements
- R1: Tag word layout: bits [31:12] virtual tag, bit 3 preserved, bit 2 valid, bits [1:0] page size, coded 0 = 1 MB, 1 = 64 KB, 2 = 4 KB, 3 = 16 MB.
- R2: Data word layout: bits [31:12] physical base, bit 9 endianness, bits [8:7] element size, bit 6 mixed-size flag; these attribute bits come out as lkEndian, lkElemSize and lkMixed on a hit.
- R3: Lock register: the victim pointer is in bits [IDXW-1:0] and the locked base in bits [16+IDXW-1:16]. A base above ENTRIES-1 is clamped to ENTRIES-1, and a written victim below the base is raised to the base.
- R4: A write to the load register with bit 0 = 1 copies the staged words into the entry at the victim pointer. With bit 0 = 0 it changes no entry and leaves the victim pointer unchanged.
- R5: After each load the victim pointer moves to the next index; from ENTRIES-1 it wraps to the locked base, not to zero.
- R6: A lookup compares VA[31:24] for 16 MB, VA[31:20] for 1 MB, VA[31:16] for 64 KB and VA[31:12] for 4 KB pages. The physical address takes the entry base bits over the compared range and the virtual address bits below it.
- R7: When several valid entries match a lookup, the lowest index supplies the result.
- R8: A lookup result appears on the outputs in the cycle after lkReq. A miss, or a cycle with no request, drives hit, address and attributes to zero.
- R9: A write of bit 0 = 1 to the single-flush register invalidates every valid entry whose page size equals the staged size and whose tag matches the staged tag over that size, including preserved entries. Other entries are left unchanged.
- R10: Any write to the global-flush register invalidates, in that same clock edge, every entry not marked preserved; preserved entries still hit afterwards.
- R11: After reset every entry is invalid, the base and victim are zero, and both staged words read as zero.
- R12: Register addresses: 0 tag word, 1 data word, 2 lock, 3 load, 4 single flush, 5 global flush. A read returns the staged tag word at 0, the staged data word at 1, the lock register at 2 and zero at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| lkReq | input | 1 | Lookup request |
| lkVa | input | 32 | Lookup virtual address |
| lkHit | output | 1 | Lookup hit, registered |
| lkPa | output | 32 | Translated physical address |
| lkEndian | output | 1 | Endianness attribute of the hit entry |
| lkElemSize | output | 2 | Element size attribute of the hit entry |
| lkMixed | output | 1 | Mixed-size attribute of the hit entry |

## Verification
The bench targets the corners where page size changes the compare. If the tag mask were wrong for one size, a large or super page would miss on an address inside it, or low address bits would leak into the physical address. It checks that the victim wraps to the locked base: a design that wrapped to zero would overwrite a locked entry, which then stops hitting. It checks flush interplay with the preserved flag: a global flush that ignored the flag would lose a preserved entry, and a single flush that honoured it would leave a stale translation. It also checks lowest-index priority with overlapping entries, and it runs random loads, flushes and lookups against a bench model of the entry array.

// File: rtl/tlbPkg.sv
package tlbPkg;

  localparam int ADDR_W   = 32;
  localparam int TAG_W    = 20;
  localparam int LOCK_LSB = 16;

  // R1 page size codes
  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_SUPER   = 2'd3
  } pageSizeT;

  // R12 register map
  typedef enum logic [2:0] {
    RA_TAGW   = 3'd0,
    RA_DATAW  = 3'd1,
    RA_LOCK   = 3'd2,
    RA_LOAD   = 3'd3,
    RA_FLUSH1 = 3'd4,
    RA_FLUSHA = 3'd5
  } regAddrT;

  typedef struct packed {
    logic             valid;
    logic             preserved;
    logic [1:0]       size;
    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] pbase;
    logic             endian;
    logic [1:0]       elemSize;
    logic             mixed;
  } tlbEntryT;

  typedef struct packed {
    logic load;
    logic flushOne;
    logic flushAll;
  } tlbStrobeT;

  // Bits of the 20-bit tag that take part in a compare (R6)
  function automatic logic [TAG_W-1:0] tagMask(input logic [1:0] size);
    case (pageSizeT'(size))
      PG_SECTION: tagMask = 20'hFFF00;
      PG_LARGE:   tagMask = 20'hFFFF0;
      PG_SMALL:   tagMask = 20'hFFFFF;
      default:    tagMask = 20'hFF000;
    endcase
  endfunction

  // R1, R2 field extraction
  function automatic tlbEntryT packEntry(input logic [31:0] tagWord,
                                         input logic [31:0] dataWord);
    tlbEntryT e;
    e.valid     = tagWord[2];
    e.preserved = tagWord[3];
    e.size      = tagWord[1:0];
    e.tag       = tagWord[31:12];
    e.pbase     = dataWord[31:12];
    e.endian    = dataWord[9];
    e.elemSize  = dataWord[8:7];
    e.mixed     = dataWord[6];
    return e;
  endfunction

endpackage

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import tlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDXW    = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [2:0]      regAddr,
  input  logic [31:0]     regWrData,
  output logic [31:0]     regRdData,
  output tlbStrobeT       strobes,
  output tlbEntryT        stagedEntry,
  output logic [IDXW-1:0] victimPtr,
  output logic [IDXW-1:0] lockBase
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(ENTRIES - 1);

  logic [31:0]     tagStage;
  logic [31:0]     dataStage;
  logic            wrTag, wrData, wrLock, wrLoad;
  logic [IDXW-1:0] newBase, newVictim, reqBase, reqVictim;
  logic [31:0]     lockWord;

  always_comb begin
    wrTag  = regWrEn && (regAddr == RA_TAGW);
    wrData = regWrEn && (regAddr == RA_DATAW);
    wrLock = regWrEn && (regAddr == RA_LOCK);
    wrLoad = regWrEn && (regAddr == RA_LOAD);
  end

  // R4, R9, R10 strobes towards the entry array
  always_comb begin
    strobes.load     = wrLoad && regWrData[0];
    strobes.flushOne = regWrEn && (regAddr == RA_FLUSH1) && regWrData[0];
    strobes.flushAll = regWrEn && (regAddr == RA_FLUSHA);
  end

  always_comb stagedEntry = packEntry(tagStage, dataStage);

  // R3 lock field clamping
  always_comb begin
    reqBase   = regWrData[LOCK_LSB +: IDXW];
    reqVictim = regWrData[0 +: IDXW];
    newBase   = (reqBase > LAST_IDX) ? LAST_IDX : reqBase;
    if (reqVictim > LAST_IDX)     newVictim = LAST_IDX;
    else if (reqVictim < newBase) newVictim = newBase;
    else                          newVictim = reqVictim;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagStage  <= '0;
      dataStage <= '0;
      victimPtr <= '0;
      lockBase  <= '0;
    end else begin
      if (wrTag)  tagStage  <= regWrData;
      if (wrData) dataStage <= regWrData;
      if (wrLock) begin
        lockBase  <= newBase;
        victimPtr <= newVictim;
      end else if (strobes.load) begin
        // R5 step forward, wrap to the locked base
        victimPtr <= (victimPtr == LAST_IDX) ? lockBase : victimPtr + 1'b1;
      end
    end
  end

  always_comb begin
    lockWord = '0;
    lockWord[0 +: IDXW]        = victimPtr;
    lockWord[LOCK_LSB +: IDXW] = lockBase;
  end

  // R12 read mux
  always_comb begin
    case (regAddr)
      RA_TAGW:  regRdData = tagStage;
      RA_DATAW: regRdData = dataStage;
      RA_LOCK:  regRdData = lockWord;
      default:  regRdData = '0;
    endcase
  end

endmodule

// File: rtl/tlbStore.sv
module tlbStore
  import tlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDXW    = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  tlbStrobeT       strobes,
  input  logic [IDXW-1:0] wrIdx,
  input  tlbEntryT        wrEntry,
  input  logic            lkReq,
  input  logic [31:0]     lkVa,
  output logic            lkHit,
  output logic [31:0]     lkPa,
  output logic            lkEndian,
  output logic [1:0]      lkElemSize,
  output logic            lkMixed
);

  tlbEntryT           entries [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] flushMatch;
  logic               anyHit;
  logic [IDXW-1:0]    selIdx;
  logic [TAG_W-1:0]   selMask;
  logic [TAG_W-1:0]   paHigh;

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    logic [TAG_W-1:0] ownMask;
    assign ownMask = tagMask(entries[i].size);

    // R6 size-dependent compare
    assign matchVec[i] = entries[i].valid &&
                         (((entries[i].tag ^ lkVa[31:12]) & ownMask) == '0);

    // R9 flush needs equal size and masked tag, preserved flag ignored
    assign flushMatch[i] = entries[i].valid &&
                           (entries[i].size == wrEntry.size) &&
                           (((entries[i].tag ^ wrEntry.tag) & ownMask) == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entries[i] <= '0;
      end else if (strobes.load && (wrIdx == IDXW'(i))) begin
        entries[i] <= wrEntry;
      end else if (strobes.flushOne && flushMatch[i]) begin
        entries[i].valid <= 1'b0;
      end else if (strobes.flushAll && !entries[i].preserved) begin
        // R10
        entries[i].valid <= 1'b0;
      end
    end
  end

  // R7 lowest index wins
  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyHit = 1'b1;
        selIdx = IDXW'(i);
      end
    end
  end

  always_comb begin
    selMask = tagMask(entries[selIdx].size);
    paHigh  = (entries[selIdx].pbase & selMask) | (lkVa[31:12] & ~selMask);
  end

  // R8 registered result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkHit      <= 1'b0;
      lkPa       <= '0;
      lkEndian   <= 1'b0;
      lkElemSize <= '0;
      lkMixed    <= 1'b0;
    end else if (lkReq && anyHit) begin
      lkHit      <= 1'b1;
      lkPa       <= {paHigh, lkVa[11:0]};
      lkEndian   <= entries[selIdx].endian;
      lkElemSize <= entries[selIdx].elemSize;
      lkMixed    <= entries[selIdx].mixed;
    end else begin
      lkHit      <= 1'b0;
      lkPa       <= '0;
      lkEndian   <= 1'b0;
      lkElemSize <= '0;
      lkMixed    <= 1'b0;
    end
  end

endmodule

// File: rtl/lockableTlb.sv
module lockableTlb
  import tlbPkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        lkReq,
  input  logic [31:0] lkVa,
  output logic        lkHit,
  output logic [31:0] lkPa,
  output logic        lkEndian,
  output logic [1:0]  lkElemSize,
  output logic        lkMixed
);

  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlbStrobeT       strobes;
  tlbEntryT        stagedEntry;
  logic [IDXW-1:0] victimPtr;
  logic [IDXW-1:0] lockBase;

  tlbCtrl #(.ENTRIES(ENTRIES), .IDXW(IDXW)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .strobes     (strobes),
    .stagedEntry (stagedEntry),
    .victimPtr   (victimPtr),
    .lockBase    (lockBase)
  );

  tlbStore #(.ENTRIES(ENTRIES), .IDXW(IDXW)) uStore (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrIdx      (victimPtr),
    .wrEntry    (stagedEntry),
    .lkReq      (lkReq),
    .lkVa       (lkVa),
    .lkHit      (lkHit),
    .lkPa       (lkPa),
    .lkEndian   (lkEndian),
    .lkElemSize (lkElemSize),
    .lkMixed    (lkMixed)
  );

endmodule

// File: rtl/lockableTlbChk.sv
module lockableTlbChk #(
  parameter int ENTRIES = 16,
  parameter int IDXW    = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            regWrEn,
  input logic [2:0]      regAddr,
  input logic            wrBit0,
  input logic            lkReq,
  input logic [11:0]     lkVaLow,
  input logic            lkHit,
  input logic [31:0]     lkPa,
  input logic [IDXW-1:0] victimPtr,
  input logic [IDXW-1:0] lockBase
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(ENTRIES - 1);

  // R3
  victim_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (victimPtr >= lockBase) && (victimPtr <= LAST_IDX));

  // R5
  victim_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd3 && wrBit0) |=>
      (victimPtr == (($past(victimPtr) == LAST_IDX) ? $past(lockBase)
                                                    : $past(victimPtr) + 1'b1)));

  // R4
  victim_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && (regAddr == 3'd2 || (regAddr == 3'd3 && wrBit0))) |=> $stable(victimPtr));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkReq |=> (!lkHit && lkPa == 32'd0));

  // R6
  pa_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkReq |=> (!lkHit || lkPa[11:0] == $past(lkVaLow)));

endmodule

bind lockableTlb lockableTlbChk #(.ENTRIES(ENTRIES), .IDXW(IDXW)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .wrBit0    (regWrData[0]),
  .lkReq     (lkReq),
  .lkVaLow   (lkVa[11:0]),
  .lkHit     (lkHit),
  .lkPa      (lkPa),
  .victimPtr (victimPtr),
  .lockBase  (lockBase)
);

// File: tb/tb_lockableTlb.sv
module tb_lockableTlb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        lkReq = 1'b0;
  logic [31:0] lkVa = '0;
  logic        lkHit;
  logic [31:0] lkPa;
  logic        lkEndian;
  logic [1:0]  lkElemSize;
  logic        lkMixed;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench model
  bit        mValid [N];
  bit        mPres [N];
  bit [1:0]  mSize [N];
  bit [19:0] mTag [N];
  bit [19:0] mBase [N];
  bit [3:0]  mAttr [N];
  int        mVic = 0;
  int        mLockBase = 0;
  bit [31:0] mTagW = 0;
  bit [31:0] mDataW = 0;

  lockableTlb #(.ENTRIES(N)) dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic bit [19:0] maskOf(bit [1:0] s);
    case (s)
      2'd0: return 20'hFFF00;
      2'd1: return 20'hFFFF0;
      2'd2: return 20'hFFFFF;
      default: return 20'hFF000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one register write, model mirrored afterwards; called at a negedge
  task automatic wr(input bit [2:0] a, input bit [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a)
      3'd0: mTagW = d;
      3'd1: mDataW = d;
      3'd2: begin
        mLockBase = int'(d[19:16]);
        mVic = int'(d[3:0]);
        if (mVic < mLockBase) mVic = mLockBase;
      end
      3'd3: if (d[0]) begin
        mValid[mVic] = mTagW[2]; mPres[mVic] = mTagW[3];
        mSize[mVic] = mTagW[1:0]; mTag[mVic] = mTagW[31:12];
        mBase[mVic] = mDataW[31:12];
        mAttr[mVic] = {mDataW[9], mDataW[8:7], mDataW[6]};
        mVic = (mVic == N - 1) ? mLockBase : mVic + 1;
      end
      3'd4: if (d[0]) begin
        for (int i = 0; i < N; i++)
          if (mValid[i] && mSize[i] == mTagW[1:0] &&
              ((mTag[i] ^ mTagW[31:12]) & maskOf(mSize[i])) == 0)
            mValid[i] = 0;
      end
      3'd5: for (int i = 0; i < N; i++) if (!mPres[i]) mValid[i] = 0;
      default: ;
    endcase
  endtask

  task automatic loadEnt(input bit [31:0] t, input bit [31:0] d);
    wr(3'd0, t); wr(3'd1, d); wr(3'd3, 32'd1);
  endtask

  task automatic lookupChk(input bit [31:0] va, input string req);
    bit hit; bit [31:0] pa; bit [3:0] at; bit [19:0] m;
    hit = 0; pa = 0; at = 0;
    for (int i = 0; i < N; i++) begin
      m = maskOf(mSize[i]);
      if (!hit && mValid[i] && ((mTag[i] ^ va[31:12]) & m) == 0) begin
        hit = 1;
        pa = {(mBase[i] & m) | (va[31:12] & ~m), va[11:0]};
        at = mAttr[i];
      end
    end
    lkReq = 1'b1; lkVa = va;
    @(negedge clk);
    lkReq = 1'b0;
    chk(lkHit == hit, req, 32'(lkHit), 32'(hit));
    chk(lkPa == pa, req, lkPa, pa);
    chk({lkEndian, lkElemSize, lkMixed} == at, req,
        32'({lkEndian, lkElemSize, lkMixed}), 32'(at));
  endtask

  task automatic readChk(input bit [2:0] a, input bit [31:0] exp, input string req);
    regAddr = a;
    #1;
    chk(regRdData == exp, req, regRdData, exp);
  endtask

  function automatic bit [31:0] lockExp();
    return (32'(mLockBase) << 16) | 32'(mVic);
  endfunction

  function automatic bit [19:0] rndTag();
    return {8'($urandom_range(0, 3)), 4'($urandom_range(0, 1)),
            4'($urandom_range(0, 1)), 4'($urandom_range(0, 1))};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0; mPres[i] = 0; mSize[i] = 0; mTag[i] = 0; mBase[i] = 0; mAttr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    readChk(3'd2, 32'd0, "R11 lock after reset");
    readChk(3'd0, 32'd0, "R11 tag word after reset");
    readChk(3'd1, 32'd0, "R11 data word after reset");
    lookupChk(32'h12345678, "R11 empty buffer misses");

    // R1 R2 R4 R6 small page with attributes
    loadEnt({20'h12345, 8'h0, 4'b0110}, {20'hABCDE, 2'b0, 1'b1, 2'b10, 1'b1, 6'b0});
    lookupChk(32'h12345678, "R1 R2 R6 small page hit");
    lookupChk(32'h12346678, "R6 small page neighbour misses");
    readChk(3'd2, 32'd1, "R5 victim advanced after load");
    // R8 idle cycle gives zero outputs
    @(negedge clk);
    chk(lkHit == 0 && lkPa == 0, "R8 idle outputs zero", lkPa, 32'd0);

    // R6 other sizes
    loadEnt({20'h80000, 8'h0, 4'b0100}, {20'h40000, 12'h0});
    loadEnt({20'h90010, 8'h0, 4'b0101}, {20'h22220, 12'h0});
    loadEnt({20'hA0000, 8'h0, 4'b0111}, {20'h05000, 12'h0});
    lookupChk(32'h80054321, "R6 section hit");
    lookupChk(32'h9001ABCD, "R6 large page hit");
    lookupChk(32'h9002ABCD, "R6 large page miss");
    lookupChk(32'hA0123456, "R6 supersection hit");

    // R4 load with bit0 clear does nothing
    wr(3'd0, {20'hCCCCC, 8'h0, 4'b0110});
    wr(3'd3, 32'd2);
    readChk(3'd2, lockExp(), "R4 victim unchanged by load bit0=0");
    lookupChk(32'hCCCCC000, "R4 no entry written by load bit0=0");

    // R12 reads
    readChk(3'd0, {20'hCCCCC, 8'h0, 4'b0110}, "R12 tag word readback");
    readChk(3'd6, 32'd0, "R12 unused address reads zero");

    // R3 victim below base is raised
    wr(3'd2, (32'd4 << 16) | 32'd2);
    readChk(3'd2, (32'd4 << 16) | 32'd4, "R3 victim raised to base");
    // R5 wrap to base
    wr(3'd2, (32'd4 << 16) | 32'd14);
    loadEnt({20'h30000, 8'h0, 4'b0100}, {20'h11100, 12'h0});
    loadEnt({20'h31000, 8'h0, 4'b0100}, {20'h11200, 12'h0});
    readChk(3'd2, (32'd4 << 16) | 32'd4, "R5 wrap to locked base");
    loadEnt({20'h32000, 8'h0, 4'b0100}, {20'h11300, 12'h0});
    lookupChk(32'h12345000, "R5 locked entry survives wrap");
    lookupChk(32'h32000010, "R5 entry at base after wrap");

    // R7 overlapping entries: a section covering a small page at lower index
    wr(3'd2, (32'd4 << 16) | 32'd6);
    loadEnt({20'h55500, 8'h0, 4'b0100}, {20'h66600, 12'h0});
    wr(3'd2, (32'd4 << 16) | 32'd5);
    loadEnt({20'h55512, 8'h0, 4'b0110}, {20'h77777, 12'h0});
    lookupChk(32'h55512345, "R7 lowest index wins");

    // R10 global flush spares preserved
    loadEnt({20'hE0000, 8'h0, 4'b1111}, {20'h0F000, 12'h0});
    wr(3'd5, 32'd0);
    lookupChk(32'hE0ABCDEF, "R10 preserved entry survives global flush");
    lookupChk(32'h12345678, "R10 ordinary entry flushed");
    lookupChk(32'h55512345, "R10 overlapping entries flushed");

    // R9 single flush removes preserved entry
    loadEnt({20'hD1000, 8'h0, 4'b0100}, {20'h0E100, 12'h0});
    wr(3'd0, {20'hE0000, 8'h0, 4'b0011});
    wr(3'd4, 32'd1);
    lookupChk(32'hE0ABCDEF, "R9 preserved entry single-flushed");
    lookupChk(32'hD1000044, "R9 other entry untouched");
    wr(3'd0, {20'hD1000, 8'h0, 4'b0010});
    wr(3'd4, 32'd1);
    lookupChk(32'hD1000044, "R9 size mismatch leaves entry");

    // random phase
    wr(3'd2, 32'd0);
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom_range(0, 99));
      if (op < 35) begin
        loadEnt({rndTag(), 8'h0, 1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 5) != 0),
                 2'($urandom_range(0, 3))}, $urandom);
      end else if (op < 85) begin
        lookupChk({rndTag(), 12'($urandom)}, "R6 R7 random lookup");
      end else if (op < 90) begin
        wr(3'd5, $urandom);
      end else if (op < 96) begin
        wr(3'd0, {rndTag(), 10'h0, 2'($urandom_range(0, 3))});
        wr(3'd4, 32'd1);
      end else begin
        wr(3'd2, (32'($urandom_range(0, 3)) << 16) | 32'($urandom_range(0, 15)));
        readChk(3'd2, lockExp(), "R3 random lock write");
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule